// File: doc/BRIEF.md
# Flash Write/Erase Controller

This block programs and erases an on-chip flash array on behalf of an 8-bit microcontroller. Software reaches it through a small set of byte-wide special-function registers: two address bytes, a data byte, a pulse-timing byte and a control byte. Writing the control byte with its write bit set, its erase bit set, or both starts a word write, a page erase, or a page erase followed by a word write. The operation uses the address held when it started.

A word holds four bytes. During a word write, software streams the four bytes through the data register one at a time. Each byte is programmed for a pulse whose length comes from the timing register. A word-busy flag tells software when the next byte may be loaded. An operation-busy flag covers the whole operation. Program pulses last one timing unit and page erases last sixty-four, counted in clock cycles.

A behavioural flash array is included for testing. An erase sets every byte of the page to 0xFF. Programming can only clear bits. A control bit picks between read enables that follow read requests and read enables that stay on continuously.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset the control (select 0), data (select 1), high address (select 2) and low address (select 3) registers read 0x00, the timing register (select 4) reads 0x2A, and op_busy and word_busy are 0.
- R2: The high address register keeps bits 6:0 and reads bit 7 as 0. The timing register keeps bits 5:0 and reads bits 7:6 as 0. Control register bits 1 (write) and 0 (erase) always read 0. Control bit 7 mirrors op_busy, bit 6 mirrors word_busy, and bit 4 reads back the read-enable mode.
- R3: A control write with bit 0 set and bit 1 clear, made while idle, raises op_busy from the next cycle for 64 x timing cycles. At the end every byte of the page selected by high-address bits 6:1 reads 0xFF, and other pages keep their contents.
- R4: A control write with bit 1 set, made while idle, starts a word write at word address {high[6:0], low[7:0]}. op_busy is 1 while word_busy is 0 until a data byte is written. The k-th byte written (k = 0..3) is programmed into rd_word bits 8k+7:8k of that word.
- R5: Programming a byte stores the old byte AND the written byte.
- R6: word_busy stays 1 for timing cycles after each data byte. op_busy stays 1 after the first three bytes and falls in the same cycle word_busy falls after the fourth.
- R7: A control write with bits 1 and 0 both set erases the addressed page first (64 x timing cycles, word_busy 0 throughout) and then performs the word write of R4.
- R8: Control register writes made while op_busy is 1 are ignored: they start nothing and do not change the read-enable mode.
- R9: flash_rd_en equals rd_req when control bit 4 is 0 and is held at 1 when control bit 4 is 1.
- R10: Pulse lengths follow the timing register value t (program t cycles, erase 64t cycles). A value of 0 gives pulses of one cycle.
- R11: A data register write made while word_busy is 1, or while no word write is in progress, programs nothing and leaves the byte in flight unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_sel | input | 3 | Register select: 0 control, 1 data, 2 high address, 3 low address, 4 timing |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Read data of the selected register |
| op_busy | output | 1 | Erase or write operation in progress |
| word_busy | output | 1 | Current data byte still being programmed |
| rd_req | input | 1 | Read request from the fetch side |
| flash_rd_en | output | 1 | Read enable to the flash array |
| rd_addr | input | 15 | Word address for array read-back |
| rd_word | output | 32 | Word read from the behavioural array |

## Verification
The bench measures every pulse in clock cycles: program pulses at the reset timing value, at a small value and at zero, and erase pulses through the cycle in which the addressed word changes to 0xFF. An off-by-one counter or a missing zero clamp shows up as a wrong count. In the erase-then-write sequence the bench checks that word_busy stays low for the whole erase and that the word is blank before any data goes in. A controller that skipped or reordered the erase would leave ANDed stale data in the word. It also writes the data register during a program pulse, writes control bits during a write, and writes data while idle. A design that let any of these through would store a zero byte, start an extra erase, set the read-enable mode or corrupt a word.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
   localparam logic [2:0] SEL_CTRL  = 3'd0;
   localparam logic [2:0] SEL_DATA  = 3'd1;
   localparam logic [2:0] SEL_ADRHI = 3'd2;
   localparam logic [2:0] SEL_ADRLO = 3'd3;
   localparam logic [2:0] SEL_TIME  = 3'd4;

   localparam int CB_BUSY   = 7;
   localparam int CB_WBUSY  = 6;
   localparam int CB_CONTRD = 4;
   localparam int CB_WRITE  = 1;
   localparam int CB_ERASE  = 0;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ERASE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_PROG  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_len,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= (load_len == '0) ? CNT_W'(1) : load_len;
      else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
   end

   assign last = (cnt_q == CNT_W'(1));

   // R10: a started pulse never has zero length
   a_r10_pulse_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q != '0));
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
   parameter int WORD_AW     = 15,
   parameter int PAGE_OFF_W  = 9,
   parameter int BYTES       = 4,
   parameter int MODEL_PAGES = 2
) (
   input  logic                     clk,
   input  logic                     erase_pulse,
   input  logic                     prog_pulse,
   input  logic [WORD_AW-1:0]       op_addr,
   input  logic [$clog2(BYTES)-1:0] prog_lane,
   input  logic [7:0]               prog_byte,
   input  logic [WORD_AW-1:0]       rd_addr,
   output logic [8*BYTES-1:0]       rd_word
);
   localparam int PG_W       = $clog2(MODEL_PAGES);
   localparam int IDX_W      = PAGE_OFF_W + PG_W;
   localparam int DEPTH      = 1 << IDX_W;
   localparam int PAGE_WORDS = 1 << PAGE_OFF_W;
   localparam int LANE_W     = $clog2(BYTES);

   if (MODEL_PAGES < 2 || (MODEL_PAGES & (MODEL_PAGES - 1)) != 0)
      $error("MODEL_PAGES must be a power of two of at least 2");
   if (IDX_W > WORD_AW)
      $error("model holds more words than the address reaches");

   logic [IDX_W-1:0] op_idx, rd_idx;
   logic [PG_W-1:0]  op_pg;
   assign op_idx = op_addr[IDX_W-1:0];
   assign rd_idx = rd_addr[IDX_W-1:0];
   assign op_pg  = op_addr[IDX_W-1:PAGE_OFF_W];

   for (genvar l = 0; l < BYTES; l++) begin : g_lane
      logic [7:0] mem [DEPTH];

      initial begin
         for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
      end

      always_ff @(posedge clk) begin
         if (erase_pulse) begin
            for (int w = 0; w < PAGE_WORDS; w++)
               mem[{op_pg, PAGE_OFF_W'(w)}] <= 8'hFF;
         end else if (prog_pulse && prog_lane == LANE_W'(l)) begin
            mem[op_idx] <= mem[op_idx] & prog_byte;
         end
      end

      assign rd_word[8*l +: 8] = mem[rd_idx];
   end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import flash_prog_pkg::*;
#(
   parameter int             ADDR_HI_W   = 7,
   parameter int             ADDR_LO_W   = 8,
   parameter int             PAGE_OFF_W  = 9,
   parameter int             BYTES       = 4,
   parameter int             TIMING_W    = 6,
   parameter int             TIMING_RST  = 42,
   parameter int             PROG_MULT   = 1,
   parameter int             ERASE_MULT  = 64,
   parameter int             MODEL_PAGES = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             sfr_we,
   input  logic [2:0]                       sfr_sel,
   input  logic [7:0]                       sfr_wdata,
   output logic [7:0]                       sfr_rdata,
   output logic                             op_busy,
   output logic                             word_busy,
   input  logic                             rd_req,
   output logic                             flash_rd_en,
   input  logic [ADDR_HI_W+ADDR_LO_W-1:0]   rd_addr,
   output logic [8*BYTES-1:0]               rd_word
);
   localparam int WORD_AW = ADDR_HI_W + ADDR_LO_W;
   localparam int LANE_W  = $clog2(BYTES);
   localparam int CNT_W   = TIMING_W + $clog2(ERASE_MULT) + 1;
   localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES - 1);

   if (ADDR_HI_W > 8 || ADDR_LO_W > 8)       $error("address bytes limited to 8 bits");
   if (TIMING_W > 8)                         $error("timing field limited to 8 bits");
   if (TIMING_RST >= (1 << TIMING_W))        $error("timing reset value does not fit");
   if (BYTES < 2 || (BYTES & (BYTES - 1)) != 0) $error("BYTES must be a power of two");
   if (PAGE_OFF_W >= WORD_AW)                $error("page offset wider than word address");
   if (PROG_MULT < 1 || PROG_MULT > ERASE_MULT) $error("pulse multipliers out of range");

   logic [ADDR_HI_W-1:0] adr_hi_q;
   logic [ADDR_LO_W-1:0] adr_lo_q;
   logic [7:0]           data_q, prog_byte_q;
   logic [TIMING_W-1:0]  time_q;
   logic                 contrd_q, wr_pend_q;
   logic [WORD_AW-1:0]   op_addr_q;
   logic [LANE_W-1:0]    lane_q;
   seq_state_e           state_q;

   logic ctrl_hit, data_hit, start, tmr_load, tmr_last;
   logic [CNT_W-1:0] tmr_len;

   assign ctrl_hit  = sfr_we && sfr_sel == SEL_CTRL;
   assign data_hit  = sfr_we && sfr_sel == SEL_DATA;
   assign op_busy   = state_q != ST_IDLE;
   assign word_busy = state_q == ST_PROG;
   assign start     = ctrl_hit && !op_busy && (sfr_wdata[CB_WRITE] || sfr_wdata[CB_ERASE]);

   assign tmr_load = (start && sfr_wdata[CB_ERASE]) || (state_q == ST_WAIT && data_hit);
   assign tmr_len  = (state_q == ST_IDLE) ? CNT_W'(time_q) * CNT_W'(ERASE_MULT)
                                          : CNT_W'(time_q) * CNT_W'(PROG_MULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_hi_q <= '0;
         adr_lo_q <= '0;
         data_q   <= '0;
         time_q   <= TIMING_W'(TIMING_RST);
         contrd_q <= 1'b0;
      end else if (sfr_we) begin
         case (sfr_sel)
            SEL_CTRL:  if (!op_busy) contrd_q <= sfr_wdata[CB_CONTRD];
            SEL_DATA:  data_q   <= sfr_wdata;
            SEL_ADRHI: adr_hi_q <= sfr_wdata[ADDR_HI_W-1:0];
            SEL_ADRLO: adr_lo_q <= sfr_wdata[ADDR_LO_W-1:0];
            SEL_TIME:  time_q   <= sfr_wdata[TIMING_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         wr_pend_q   <= 1'b0;
         op_addr_q   <= '0;
         lane_q      <= '0;
         prog_byte_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               op_addr_q <= {adr_hi_q, adr_lo_q};
               wr_pend_q <= sfr_wdata[CB_WRITE];
               lane_q    <= '0;
               state_q   <= sfr_wdata[CB_ERASE] ? ST_ERASE : ST_WAIT;
            end
            ST_ERASE: if (tmr_last) state_q <= wr_pend_q ? ST_WAIT : ST_IDLE;
            ST_WAIT: if (data_hit) begin
               prog_byte_q <= sfr_wdata;
               state_q     <= ST_PROG;
            end
            ST_PROG: if (tmr_last) begin
               lane_q  <= lane_q + LANE_W'(1);
               state_q <= (lane_q == LAST_LANE) ? ST_IDLE : ST_WAIT;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      sfr_rdata = '0;
      case (sfr_sel)
         SEL_CTRL: begin
            sfr_rdata[CB_BUSY]   = op_busy;
            sfr_rdata[CB_WBUSY]  = word_busy;
            sfr_rdata[CB_CONTRD] = contrd_q;
         end
         SEL_DATA:  sfr_rdata = data_q;
         SEL_ADRHI: sfr_rdata = 8'(adr_hi_q);
         SEL_ADRLO: sfr_rdata = 8'(adr_lo_q);
         SEL_TIME:  sfr_rdata = 8'(time_q);
         default:   sfr_rdata = '0;
      endcase
   end

   assign flash_rd_en = contrd_q | rd_req;

   flash_pulse_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_len (tmr_len),
      .last     (tmr_last)
   );

   flash_array_model #(
      .WORD_AW     (WORD_AW),
      .PAGE_OFF_W  (PAGE_OFF_W),
      .BYTES       (BYTES),
      .MODEL_PAGES (MODEL_PAGES)
   ) i_array (
      .clk         (clk),
      .erase_pulse (state_q == ST_ERASE && tmr_last),
      .prog_pulse  (state_q == ST_PROG && tmr_last),
      .op_addr     (op_addr_q),
      .prog_lane   (lane_q),
      .prog_byte   (prog_byte_q),
      .rd_addr     (rd_addr),
      .rd_word     (rd_word)
   );

   // R6: word-level busy only inside an operation
   a_r6_word_in_op: assert property (@(posedge clk) disable iff (!rst_n)
      word_busy |-> op_busy);
   // R6: the pulse of the last byte closes the operation
   a_r6_last_byte_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (word_busy && tmr_last && lane_q == LAST_LANE) |=> !op_busy);
   // R3: an accepted trigger raises op_busy next cycle
   a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> op_busy);
   // R8: control writes during an operation keep the read mode
   a_r8_ctrl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (op_busy && ctrl_hit) |=> $stable(contrd_q));
   // R11: data written while idle starts no program pulse
   a_r11_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_busy && data_hit) |=> !word_busy);
endmodule

// File: tb/test_flash_prog_ctrl.sv
`timescale 1ns/1ps
module test_flash_prog_ctrl;
   import flash_prog_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sfr_we = 1'b0;
   logic [2:0]  sfr_sel = 3'd0;
   logic [7:0]  sfr_wdata = 8'd0;
   logic [7:0]  sfr_rdata;
   logic        op_busy, word_busy;
   logic        rd_req = 1'b0;
   logic        flash_rd_en;
   logic [14:0] rd_addr = 15'd0;
   logic [31:0] rd_word;

   int vecs = 0;
   int errs = 0;

   always #2 clk = ~clk;

   flash_prog_ctrl i_flash_prog_ctrl (
      .clk, .rst_n, .sfr_we, .sfr_sel, .sfr_wdata, .sfr_rdata,
      .op_busy, .word_busy, .rd_req, .flash_rd_en, .rd_addr, .rd_word
   );

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk);
      sfr_sel = sel; sfr_wdata = d; sfr_we = 1'b1;
      @(negedge clk);
      sfr_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] sel, input logic [7:0] exp,
                         input string req, input string what);
      sfr_sel = sel;
      #0.5;
      chk(req, what, 32'(sfr_rdata), 32'(exp));
   endtask

   task automatic word_chk(input logic [14:0] a, input logic [31:0] exp,
                           input string req, input string what);
      rd_addr = a;
      #0.5;
      chk(req, what, rd_word, exp);
   endtask

   // one data byte: word_busy length and op_busy afterwards
   task automatic prog(input logic [7:0] d, input int len, input bit last,
                       input string req);
      int n = 0;
      wr(SEL_DATA, d);
      while (word_busy === 1'b1 && n < 10000) begin n++; @(negedge clk); end
      chk(req, "word_busy cycles", 32'(n), 32'(len));
      chk("R6", "op_busy after byte", 32'(op_busy), last ? 32'd0 : 32'd1);
   endtask

   task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
      wr(SEL_ADRHI, hi);
      wr(SEL_ADRLO, lo);
   endtask

   task automatic t_reset();
      rd_chk(SEL_CTRL,  8'h00, "R1", "ctrl reset");
      rd_chk(SEL_DATA,  8'h00, "R1", "data reset");
      rd_chk(SEL_ADRHI, 8'h00, "R1", "adr hi reset");
      rd_chk(SEL_ADRLO, 8'h00, "R1", "adr lo reset");
      rd_chk(SEL_TIME,  8'h2A, "R1", "timing reset");
      chk("R1", "busy flags reset", {30'd0, op_busy, word_busy}, 32'd0);
   endtask

   task automatic t_fields();
      wr(SEL_ADRHI, 8'hFF); rd_chk(SEL_ADRHI, 8'h7F, "R2", "adr hi bit7");
      wr(SEL_ADRLO, 8'hA5); rd_chk(SEL_ADRLO, 8'hA5, "R2", "adr lo");
      wr(SEL_TIME, 8'hFF);  rd_chk(SEL_TIME,  8'h3F, "R2", "timing bits 7:6");
      wr(SEL_TIME, 8'h2A);
      wr(SEL_CTRL, 8'h10);  rd_chk(SEL_CTRL, 8'h10, "R2", "read mode bit");
      chk("R9", "rd_en continuous", 32'(flash_rd_en), 32'd1);
      wr(SEL_CTRL, 8'h00);
      chk("R9", "rd_en idle", 32'(flash_rd_en), 32'd0);
      rd_req = 1'b1; #0.5;
      chk("R9", "rd_en on request", 32'(flash_rd_en), 32'd1);
      rd_req = 1'b0;
   endtask

   task automatic t_word_default();
      set_addr(8'h02, 8'h05);
      wr(SEL_CTRL, 8'h02);
      rd_chk(SEL_CTRL, 8'h80, "R4", "busy, waiting for data, trigger bits 0");
      prog(8'h11, 42, 0, "R10");
      prog(8'h22, 42, 0, "R4");
      prog(8'h33, 42, 0, "R4");
      prog(8'h44, 42, 1, "R6");
      word_chk(15'h0205, 32'h44332211, "R4", "word lanes");
   endtask

   task automatic t_word_fast();
      wr(SEL_TIME, 8'h03);
      set_addr(8'h00, 8'h05);
      wr(SEL_CTRL, 8'h02);
      prog(8'hAA, 3, 0, "R10");
      prog(8'hBB, 3, 0, "R4");
      prog(8'hCC, 3, 0, "R4");
      prog(8'hDD, 3, 1, "R6");
      word_chk(15'h0005, 32'hDDCCBBAA, "R4", "page0 word");
   endtask

   task automatic t_erase();
      int n = 0;
      set_addr(8'h02, 8'h77);
      rd_addr = 15'h0205;
      wr(SEL_CTRL, 8'h01);
      while (rd_word !== 32'hFFFFFFFF && n < 10000) begin
         if (op_busy !== 1'b1) chk("R3", "busy during erase", 32'(op_busy), 32'd1);
         n++; @(negedge clk);
      end
      chk("R3", "erase cycles", 32'(n), 32'd192);
      chk("R3", "busy after erase", 32'(op_busy), 32'd0);
      word_chk(15'h0005, 32'hDDCCBBAA, "R3", "other page kept");
   endtask

   task automatic t_and();
      set_addr(8'h00, 8'h05);
      wr(SEL_CTRL, 8'h02);
      prog(8'h0F, 3, 0, "R5");
      prog(8'hF0, 3, 0, "R5");
      prog(8'hFF, 3, 0, "R5");
      prog(8'h00, 3, 1, "R5");
      word_chk(15'h0005, 32'h00CCB00A, "R5", "AND programming");
   endtask

   task automatic t_erase_write();
      int n = 0;
      bit wb = 0;
      rd_addr = 15'h0005;
      wr(SEL_CTRL, 8'h03);
      while (rd_word !== 32'hFFFFFFFF && n < 10000) begin
         wb |= word_busy; n++; @(negedge clk);
      end
      chk("R7", "erase cycles before write", 32'(n), 32'd192);
      chk("R7", "word_busy during erase", 32'(wb), 32'd0);
      chk("R7", "waiting after erase", {30'd0, op_busy, word_busy}, 32'd2);
      prog(8'h12, 3, 0, "R7");
      prog(8'h34, 3, 0, "R7");
      prog(8'h56, 3, 0, "R7");
      prog(8'h78, 3, 1, "R7");
      word_chk(15'h0005, 32'h78563412, "R7", "word after erase+write");
   endtask

   task automatic t_busy_ignore();
      set_addr(8'h00, 8'h06);
      wr(SEL_CTRL, 8'h02);
      wr(SEL_CTRL, 8'h11);
      rd_chk(SEL_CTRL, 8'h80, "R8", "ctrl during op");
      chk("R8", "rd_en mode kept", 32'(flash_rd_en), 32'd0);
      prog(8'hF1, 3, 0, "R8");
      prog(8'hF2, 3, 0, "R8");
      prog(8'hF3, 3, 0, "R8");
      prog(8'hF4, 3, 1, "R8");
      repeat (250) @(negedge clk);
      chk("R8", "no late operation", 32'(op_busy), 32'd0);
      word_chk(15'h0006, 32'hF4F3F2F1, "R8", "word not erased");
      word_chk(15'h0005, 32'h78563412, "R8", "page neighbour kept");
   endtask

   task automatic t_inflight();
      int n = 0;
      wr(SEL_TIME, 8'h05);
      set_addr(8'h00, 8'h07);
      wr(SEL_CTRL, 8'h02);
      wr(SEL_DATA, 8'h5A);
      wr(SEL_DATA, 8'h00);
      chk("R11", "still programming", 32'(word_busy), 32'd1);
      while (word_busy === 1'b1 && n < 100) begin n++; @(negedge clk); end
      chk("R11", "waiting for lane1", {30'd0, op_busy, word_busy}, 32'd2);
      prog(8'h01, 5, 0, "R11");
      prog(8'h02, 5, 0, "R11");
      prog(8'h03, 5, 1, "R11");
      word_chk(15'h0007, 32'h0302015A, "R11", "byte in flight kept");
      wr(SEL_DATA, 8'h00);
      chk("R11", "idle data write", {30'd0, op_busy, word_busy}, 32'd0);
      repeat (10) @(negedge clk);
      word_chk(15'h0007, 32'h0302015A, "R11", "idle data no program");
   endtask

   task automatic t_zero_timing();
      int n = 0;
      wr(SEL_TIME, 8'h00);
      set_addr(8'h00, 8'h08);
      wr(SEL_CTRL, 8'h01);
      while (op_busy === 1'b1 && n < 100) begin n++; @(negedge clk); end
      chk("R10", "zero timing erase cycles", 32'(n), 32'd1);
      word_chk(15'h0005, 32'hFFFFFFFF, "R3", "page0 erased");
      wr(SEL_CTRL, 8'h02);
      prog(8'h9A, 1, 0, "R10");
      prog(8'hBC, 1, 0, "R10");
      prog(8'hDE, 1, 0, "R10");
      prog(8'hF0, 1, 1, "R10");
      word_chk(15'h0008, 32'hF0DEBC9A, "R10", "zero timing word");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_word_default();
      t_word_fast();
      t_erase();
      t_and();
      t_erase_write();
      t_busy_ignore();
      t_inflight();
      t_zero_timing();
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end
endmodule